// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the digital timing controller that sits beside a successive-approximation converter. It runs from a reference clock at twice the instruction rate and derives the conversion time unit (the TAD tick) from it with a programmable divider. Each TAD lasts a programmable number of half instruction cycles. Instead of the divider, an external slow tick (for example, from an on-chip RC oscillator) can supply the TAD ticks. The sequencer drives an acquisition phase and then a conversion phase of twelve TAD. When a conversion completes, it writes the converter's result into a buffer register and raises a one-cycle completion pulse.

A three-bit source select chooses what ends acquisition. Code 0 gives software control: acquisition runs until the sample request bit is cleared. Code 7 gives auto-start: acquisition lasts a programmed number of TAD (a zero setting counts as one). Codes 1 to 6 each pick one hardware trigger line. A pulse on that line is followed by a two-TAD synchronisation wait before conversion begins. Dropping the enable input at any point of an active sequence aborts it. An abort leaves the buffer untouched, wins over a coincident auto-start, and is followed by a two-TAD recovery time during which no new acquisition may begin.

Top module: `adc_trig_seq`

## Requirements
- R1: With `useExtTick` low, one TAD spans `divSel`+1 reference clock cycles, and every phase is a whole number of TAD, counted from the cycle the phase begins.
- R2: In auto-start mode (`trigSrc` = 7), `sampling` stays high for `sampleTime` TAD, and a `sampleTime` of 0 behaves as 1.
- R3: `converting` stays high for exactly 12 TAD. In the cycle after it falls, `bufWe`, `donePulse` and `irqFlag` are high for one cycle, and `bufData` holds the `convResult` value present in the last conversion cycle. `sampling` and `converting` are never high together.
- R4: In software mode (`trigSrc` = 0), acquisition lasts as long as `sampleReq` stays high. The cycle after `sampleReq` is seen low, `sampling` is low and `converting` is high.
- R5: Code k in 1..6 selects `hwTrig[k-1]`. A pulse on it during acquisition keeps `sampling` high for exactly 2 more TAD before conversion begins. Pulses on other lines have no effect.
- R6: From idle, `sampling` rises one cycle after `enable` and `sampleReq` are both seen high, and it stays low while `enable` is low. In auto-start mode a new acquisition begins the cycle after a write if `sampleReq` is still high.
- R7: Seeing `enable` low during acquisition, synchronisation or conversion drops `sampling` and `converting` in the next cycle. No buffer write follows, and `bufData` keeps its previous value.
- R8: If `enable` is seen low in the same cycle as the final auto-start sample tick, the abort wins and `converting` does not rise.
- R9: After an abort, `sampling` stays low for 2 TAD plus one idle cycle (2·(`divSel`+1)+1 cycles), even if `enable` and `sampleReq` return high at once.
- R10: With `useExtTick` high, each cycle in which `extTick` is high counts as one TAD, and `divSel` has no effect.
- R11: During and right after reset, `sampling`, `converting`, `bufWe`, `donePulse`, `irqFlag` are low and `bufData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, twice the instruction rate |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Converter enable; dropping it aborts |
| divSel | input | 6 | TAD length minus one, in reference cycles |
| useExtTick | input | 1 | Take TAD ticks from `extTick` instead of the divider |
| extTick | input | 1 | External TAD tick, one cycle wide |
| trigSrc | input | 3 | Trigger source: 0 software, 1..6 hardware line, 7 auto-start |
| sampleTime | input | 5 | Auto-start acquisition length in TAD |
| sampleReq | input | 1 | Sample request bit |
| hwTrig | input | 6 | Hardware trigger lines |
| convResult | input | 10 | Converter result, valid at the end of conversion |
| sampling | output | 1 | Acquisition phase active |
| converting | output | 1 | Conversion phase active |
| bufWe | output | 1 | Result buffer write strobe |
| bufData | output | 10 | Result buffer |
| donePulse | output | 1 | One-cycle completion pulse |
| irqFlag | output | 1 | One-cycle interrupt request |

## Verification
A divider or phase counter that is off by one shows up at once as a `sampling` or `converting` window that is one cycle or one TAD too long or too short. The bench sweeps divisor and sample-time settings so that every such error is caught within a single sequence. A stuck or mis-sequenced state shows up within one cycle: both phase outputs high together, a missing write after `converting` falls, or a write after an abort. A recovery counter that is too short lets `sampling` rise early after an abort, which is visible within 2·(`divSel`+1)+1 cycles.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_SYNC,
    ST_CONV,
    ST_RECOVER
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // clear divider and TAD counter at phase entry
    logic writeBuf;  // capture converter result
  } seqStrobe_t;

endpackage

// File: rtl/adcseq_tad_div.sv
module adcseq_tad_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic [DIV_W-1:0] divSel,
  input  logic             useExtTick,
  input  logic             extTick,
  output logic             tadTick
);

  logic [DIV_W-1:0] halfCnt;
  logic             wrap;

  // >= guards against divSel shrinking mid-count
  assign wrap = (halfCnt >= divSel);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (restart || wrap) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= halfCnt + 1'b1;
    end
  end

  assign tadTick = useExtTick ? extTick : wrap;

endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int CNT_W = 5,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [DIV_W-1:0] divSel,
  input  logic             useExtTick,
  input  logic             extTick,
  input  logic [RES_W-1:0] convResult,
  output logic             tadTick,
  output logic [CNT_W-1:0] tickCnt,
  output logic [RES_W-1:0] bufData,
  output logic             bufWe,
  output logic             donePulse,
  output logic             irqFlag
);

  adcseq_tad_div #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rstN       (rstN),
    .restart    (strobe.restart),
    .divSel     (divSel),
    .useExtTick (useExtTick),
    .extTick    (extTick),
    .tadTick    (tadTick)
  );

  // TAD ticks elapsed in the current phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.restart) begin
      tickCnt <= '0;
    end else if (tadTick) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData   <= '0;
      bufWe     <= 1'b0;
      donePulse <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (strobe.writeBuf) begin
        bufData <= convResult;
      end
      bufWe     <= strobe.writeBuf;
      donePulse <= strobe.writeBuf;
      irqFlag   <= strobe.writeBuf;
    end
  end

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int SRC_W       = 3,
  parameter int SAMC_W      = 5,
  parameter int CNT_W       = 5,
  parameter int CONV_TAD    = 12,
  parameter int SYNC_TAD    = 2,
  parameter int RECOVER_TAD = 2,
  localparam int NUM_HW     = (1 << SRC_W) - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [SRC_W-1:0]  trigSrc,
  input  logic [SAMC_W-1:0] sampleTime,
  input  logic              sampleReq,
  input  logic [NUM_HW-1:0] hwTrig,
  input  logic              tadTick,
  input  logic [CNT_W-1:0]  tickCnt,
  output seqStrobe_t        strobe,
  output logic              sampling,
  output logic              converting
);

  seqState_t state, nextState;

  logic              isSoft, isAuto, hwHit;
  logic [SAMC_W-1:0] samcEff;
  logic              sampleDone, syncDone, convDone, recoverDone;

  assign isSoft  = (trigSrc == '0);
  assign isAuto  = (trigSrc == {SRC_W{1'b1}});
  assign samcEff = (sampleTime == '0) ? SAMC_W'(1) : sampleTime;

  assign sampleDone  = tadTick && (tickCnt == CNT_W'(samcEff - SAMC_W'(1)));
  assign syncDone    = tadTick && (tickCnt == CNT_W'(SYNC_TAD - 1));
  assign convDone    = tadTick && (tickCnt == CNT_W'(CONV_TAD - 1));
  assign recoverDone = tadTick && (tickCnt == CNT_W'(RECOVER_TAD - 1));

  // hardware line k-1 belongs to source code k
  always_comb begin
    hwHit = 1'b0;
    for (int i = 0; i < NUM_HW; i++) begin
      if (trigSrc == SRC_W'(i + 1) && hwTrig[i]) begin
        hwHit = 1'b1;
      end
    end
  end

  always_comb begin
    nextState       = state;
    strobe.writeBuf = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable && sampleReq) nextState = ST_SAMPLE;
      end
      ST_SAMPLE: begin
        if (!enable)                         nextState = ST_RECOVER;
        else if (isSoft && !sampleReq)       nextState = ST_CONV;
        else if (isAuto && sampleDone)       nextState = ST_CONV;
        else if (!isSoft && !isAuto && hwHit) nextState = ST_SYNC;
      end
      ST_SYNC: begin
        if (!enable)       nextState = ST_RECOVER;
        else if (syncDone) nextState = ST_CONV;
      end
      ST_CONV: begin
        if (!enable) begin
          nextState = ST_RECOVER;
        end else if (convDone) begin
          nextState       = ST_IDLE;
          strobe.writeBuf = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (recoverDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.restart = (state == ST_IDLE) || (nextState != state);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= nextState;
    end
  end

  assign sampling   = (state == ST_SAMPLE) || (state == ST_SYNC);
  assign converting = (state == ST_CONV);

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adcseq_pkg::*;
#(
  parameter int DIV_W       = 6,
  parameter int SRC_W       = 3,
  parameter int SAMC_W      = 5,
  parameter int RES_W       = 10,
  parameter int CONV_TAD    = 12,
  parameter int SYNC_TAD    = 2,
  parameter int RECOVER_TAD = 2,
  localparam int NUM_HW     = (1 << SRC_W) - 2,
  localparam int CONV_CW    = $clog2(CONV_TAD + 1),
  localparam int CNT_W      = (SAMC_W > CONV_CW) ? SAMC_W : CONV_CW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              useExtTick,
  input  logic              extTick,
  input  logic [SRC_W-1:0]  trigSrc,
  input  logic [SAMC_W-1:0] sampleTime,
  input  logic              sampleReq,
  input  logic [NUM_HW-1:0] hwTrig,
  input  logic [RES_W-1:0]  convResult,
  output logic              sampling,
  output logic              converting,
  output logic              bufWe,
  output logic [RES_W-1:0]  bufData,
  output logic              donePulse,
  output logic              irqFlag
);

  seqStrobe_t       strobe;
  logic             tadTick;
  logic [CNT_W-1:0] tickCnt;

  adcseq_ctrl #(
    .SRC_W       (SRC_W),
    .SAMC_W      (SAMC_W),
    .CNT_W       (CNT_W),
    .CONV_TAD    (CONV_TAD),
    .SYNC_TAD    (SYNC_TAD),
    .RECOVER_TAD (RECOVER_TAD)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .trigSrc    (trigSrc),
    .sampleTime (sampleTime),
    .sampleReq  (sampleReq),
    .hwTrig     (hwTrig),
    .tadTick    (tadTick),
    .tickCnt    (tickCnt),
    .strobe     (strobe),
    .sampling   (sampling),
    .converting (converting)
  );

  adcseq_datapath #(
    .DIV_W (DIV_W),
    .CNT_W (CNT_W),
    .RES_W (RES_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .divSel     (divSel),
    .useExtTick (useExtTick),
    .extTick    (extTick),
    .convResult (convResult),
    .tadTick    (tadTick),
    .tickCnt    (tickCnt),
    .bufData    (bufData),
    .bufWe      (bufWe),
    .donePulse  (donePulse),
    .irqFlag    (irqFlag)
  );

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             sampleReq,
  input logic             sampling,
  input logic             converting,
  input logic             bufWe,
  input logic [RES_W-1:0] bufData
);

  AST_PHASE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(sampling && converting)); // R3

  AST_WRITE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |-> ($past(converting) && $past(enable))); // R3

  AST_COMPLETE_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(converting) && $past(enable)) |-> bufWe); // R3

  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    bufWe |=> !bufWe); // R3

  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampling) |-> ($past(enable) && $past(sampleReq))); // R6

  AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (($past(sampling) || $past(converting)) && !$past(enable))
      |-> (!sampling && !converting && !bufWe)); // R7

  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !bufWe |-> $stable(bufData)); // R7

  AST_RECOVER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (($past(sampling) || $past(converting)) && !$past(enable)) |=> !sampling); // R9

endmodule

bind adc_trig_seq adcseq_chk #(.RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .sampleReq  (sampleReq),
  .sampling   (sampling),
  .converting (converting),
  .bufWe      (bufWe),
  .bufData    (bufData)
);

// File: tb/adc_trig_seq_bench.sv
`timescale 1ns/1ps
module adc_trig_seq_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [5:0] divSel = '0;
  logic       useExtTick = 1'b0;
  logic       extTick = 1'b0;
  logic [2:0] trigSrc = 3'd7;
  logic [4:0] sampleTime = '0;
  logic       sampleReq = 1'b0;
  logic [5:0] hwTrig = '0;
  logic [9:0] convResult = '0;
  logic       sampling, converting, bufWe, donePulse, irqFlag;
  logic [9:0] bufData;

  int nChecks = 0;
  int nErr = 0;

  always #4 clk = ~clk;

  adc_trig_seq u_adc_trig_seq (
    .clk(clk), .rstN(rstN), .enable(enable), .divSel(divSel),
    .useExtTick(useExtTick), .extTick(extTick), .trigSrc(trigSrc),
    .sampleTime(sampleTime), .sampleReq(sampleReq), .hwTrig(hwTrig),
    .convResult(convResult), .sampling(sampling), .converting(converting),
    .bufWe(bufWe), .bufData(bufData), .donePulse(donePulse), .irqFlag(irqFlag)
  );

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nextCyc();
    @(negedge clk);
  endtask

  task automatic countHigh(input bit useConv, output int n);
    n = 0;
    while ((useConv ? converting : sampling) && n < 10000) begin
      n++;
      nextCyc();
    end
  endtask

  task automatic settle();
    sampleReq = 1'b0;
    enable = 1'b1;
    repeat (140) nextCyc();
  endtask

  // auto-start run; R1 R2 R3 R6
  task automatic runAuto(int d, int s, logic [9:0] val, bit again);
    int n;
    nextCyc();
    trigSrc = 3'd7; divSel = 6'(d); sampleTime = 5'(s); useExtTick = 1'b0;
    convResult = val; enable = 1'b1; sampleReq = 1'b1;
    nextCyc();
    check("R6", "sampling one cycle after request", int'(sampling), 1);
    countHigh(1'b0, n);
    check("R2", $sformatf("sample length d=%0d s=%0d", d, s), n, ((s == 0) ? 1 : s) * (d + 1));
    countHigh(1'b1, n);
    check("R1", $sformatf("conversion length d=%0d", d), n, 12 * (d + 1));
    check("R3", "write strobes after conversion",
          int'({bufWe, donePulse, irqFlag}), 7);
    check("R3", "buffer value", int'(bufData), int'(val));
    if (!again) sampleReq = 1'b0;
    nextCyc();
    check("R3", "write strobe single cycle", int'(bufWe), 0);
    if (again) begin
      check("R6", "auto restart with request held", int'(sampling), 1);
      sampleReq = 1'b0;
      countHigh(1'b0, n);
      countHigh(1'b1, n);
      nextCyc();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int n;
    logic [9:0] prev;
    repeat (4) nextCyc();
    check("R11", "outputs during reset",
          int'({sampling, converting, bufWe, donePulse, irqFlag}), 0);
    rstN = 1'b1;
    nextCyc();
    check("R11", "outputs after reset",
          int'({sampling, converting, bufWe, donePulse, irqFlag}), 0);
    check("R11", "buffer after reset", int'(bufData), 0);

    // disabled: request ignored (R6)
    sampleReq = 1'b1;
    repeat (8) nextCyc();
    check("R6", "no sampling while disabled", int'(sampling), 0);
    sampleReq = 1'b0;
    nextCyc();

    // sweep divisor and sample time (R1 R2 R3)
    foreach (divSel[i]) begin end
    for (int di = 0; di < 5; di++) begin
      for (int si = 0; si < 6; si++) begin
        int dv[5] = '{0, 1, 2, 5, 63};
        int sv[6] = '{0, 1, 2, 3, 7, 31};
        runAuto(dv[di], sv[si], 10'((di * 97 + si * 31 + 5) & 10'h3ff), 1'b0);
      end
    end
    runAuto(1, 2, 10'h2a5, 1'b1);

    // software trigger (R4)
    nextCyc();
    trigSrc = 3'd0; divSel = 6'd2; convResult = 10'h155; sampleReq = 1'b1;
    repeat (20) nextCyc();
    check("R4", "still sampling while request high", int'({sampling, converting}), 2);
    sampleReq = 1'b0;
    nextCyc();
    check("R4", "conversion starts after clear", int'({sampling, converting}), 1);
    countHigh(1'b1, n);
    check("R4", "software conversion length", n, 36);
    check("R4", "software result", int'(bufData), 'h155);
    nextCyc();

    // hardware trigger per code (R5)
    for (int code = 1; code <= 6; code++) begin
      nextCyc();
      trigSrc = 3'(code); divSel = 6'd1; convResult = 10'(code * 100);
      sampleReq = 1'b1;
      repeat (4) nextCyc();
      hwTrig[code % 6] = 1'b1;
      nextCyc();
      hwTrig = '0;
      repeat (6) nextCyc();
      check("R5", $sformatf("other line ignored code=%0d", code),
            int'({sampling, converting}), 2);
      sampleReq = 1'b0;
      hwTrig[code - 1] = 1'b1;
      nextCyc();
      hwTrig = '0;
      countHigh(1'b0, n);
      check("R5", $sformatf("sync wait code=%0d", code), n, 4);
      countHigh(1'b1, n);
      check("R5", $sformatf("conversion code=%0d", code), n, 24);
      check("R5", $sformatf("result code=%0d", code), int'(bufData), code * 100);
      nextCyc();
    end

    // abort mid-conversion and on final tick (R7)
    for (int ab = 0; ab < 2; ab++) begin
      nextCyc();
      prev = bufData;
      trigSrc = 3'd7; divSel = 6'd2; sampleTime = 5'd1; convResult = 10'h3c3;
      sampleReq = 1'b1;
      nextCyc();
      countHigh(1'b0, n);
      n = 1;
      while (n < ((ab == 0) ? 5 : 36)) begin
        nextCyc();
        n++;
      end
      enable = 1'b0;
      sampleReq = 1'b0;
      nextCyc();
      check("R7", "abort drops phases", int'({sampling, converting, bufWe}), 0);
      repeat (10) nextCyc();
      check("R7", "buffer kept after abort", int'(bufData), int'(prev));
      settle();
    end

    // abort coinciding with auto-start, then recovery (R8 R9)
    nextCyc();
    prev = bufData;
    trigSrc = 3'd7; divSel = 6'd3; sampleTime = 5'd1; convResult = 10'h0f0;
    sampleReq = 1'b1;
    nextCyc();
    n = 1;
    while (n < 4) begin
      nextCyc();
      n++;
    end
    check("R8", "sampling in final tick cycle", int'(sampling), 1);
    enable = 1'b0;
    nextCyc();
    check("R8", "abort beats auto start", int'({sampling, converting}), 0);
    enable = 1'b1;
    n = 0;
    while (!sampling && n < 1000) begin
      n++;
      nextCyc();
    end
    check("R9", "recovery gap", n, 9);
    check("R8", "buffer untouched", int'(bufData), int'(prev));
    settle();

    // external tick source (R10)
    nextCyc();
    trigSrc = 3'd7; divSel = 6'd63; sampleTime = 5'd2; useExtTick = 1'b1;
    convResult = 10'h1e1; sampleReq = 1'b1; extTick = 1'b0;
    begin
      int sCnt = 0, cCnt = 0, wr = 0;
      for (int k = 1; k <= 50; k++) begin
        nextCyc();
        if (sampling) sCnt++;
        if (converting) cCnt++;
        if (bufWe) wr++;
        extTick = ((k % 3) == 2);
        if (k == 1) sampleReq = 1'b0;
      end
      check("R10", "sample length with external tick", sCnt, 5);
      check("R10", "conversion length with external tick", cCnt, 36);
      check("R10", "single write", wr, 1);
      check("R10", "result", int'(bufData), 'h1e1);
    end
    extTick = 1'b0;
    useExtTick = 1'b0;
    repeat (4) nextCyc();

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule